// File: doc/BRIEF.md
# Dual Table Interlaced Display Sequencer

This block keeps two waveform tables of 500 equally spaced points each in one shared 1024 x 8 memory and turns them into a stream of display points. The acquisition side walks a half-step position counter from 0 to 999. Each sample strobe stores one Y byte: even positions go to table A and odd positions go to table B, so the two tables interlace. Table B is refreshed on every sweep. Table A is refreshed only while the save-A control is low.

The display side runs its own step counter and reads the tables back as frames. Each frame contains A only, B only, both tables, or the arithmetic B-minus-A view. With both tables selected, the frame is one merged trace of 1000 interleaved points when save-A is low, or two separate traces when save-A is high. A single 10-bit address multiplexer chooses which counter reaches the memory. A write always wins the memory port, and the display step waits while the write is in progress.

When the X of the next display read equals the acquisition position, the display holds for a fixed number of cycles and raises a marker signal. This holding intensifies the update point on the screen.

Top module: `dts_sequencer`

## Requirements
- R1: After reset, `disp_valid` and `marker_pause` are low and the acquisition position is 0.
- R2: Each `acq_strobe` at acquisition position p stores `acq_data` into A[p/2] when p is even and into B[(p-1)/2] when p is odd. The position then advances by one and wraps from 999 back to 0.
- R3: While `save_a` is high, strobes at even positions leave table A unchanged. The position still advances, and table B is still written.
- R4: View code 0 (A only) produces 500 points in the order i = 0..499, each with x = 2i, y = A[i] and trace 0.
- R5: View code 1 (B only) produces 500 points with x = 2i+1, y = B[i] and trace 0.
- R6: View code 2 with `save_a` low produces 1000 points with x = k for k = 0..999. Even k carries A[k/2], odd k carries B[k/2], and every point uses trace 0.
- R7: View code 2 with `save_a` high produces 500 points (x = 2i, A[i], trace 0), followed by 500 points (x = 2i+1, B[i], trace 1).
- R8: View code 3 produces 500 points with x = 2i and trace 2. Each y is 128 + B[i] - A[i], clamped to the range 0..255.
- R9: A cycle with a memory write issues no display read. Once strobes are held back to back, `disp_valid` stays low from the third strobe cycle onward.
- R10: When the X of the pending display read equals the acquisition position, `marker_pause` is high for exactly PAUSE_CYC cycles (default 4) before that read, once per read. No pause happens when no read X matches.
- R11: `view_sel` and `save_a` are sampled at step 0 of each frame, so a change in the middle of a frame has no effect until the next frame. Frames repeat while `disp_run` is high, and lowering `disp_run` restarts the display at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (1 MHz system rate) |
| rst | input | 1 | Synchronous active-high reset |
| acq_strobe | input | 1 | One acquired Y sample for the current position |
| acq_data | input | 8 | Y sample value |
| save_a | input | 1 | Freeze table A; split the both-tables view into two traces |
| view_sel | input | 2 | 0 A only, 1 B only, 2 both tables, 3 B minus A |
| disp_run | input | 1 | Display enable; low restarts at step 0 |
| disp_valid | output | 1 | A display point is present this cycle |
| disp_x | output | 10 | Display X code in half steps (0..999) |
| disp_y | output | 8 | Display Y value |
| disp_trace | output | 2 | 0 main trace, 1 second trace, 2 arithmetic trace |
| marker_pause | output | 1 | Display holding at the update point |

## Verification
The tables are loaded with two distinct arithmetic sequences, so the bench can tell A data from B data and one sweep from the next. Reading the tables in all four views, with and without save-A, shows whether the order, the X codes and the trace numbers match each view. In the difference view, the sequence pair drives many points past both clamp limits. A short partial sweep moves the acquisition position to an odd value. The marker is then expected in the merged view and absent in the A-only view. In the same A-only frame, a view change in the middle of the frame must have no effect. A burst of back-to-back strobes shows that the display stops once writes hold the port.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int PTS    = 500;          // points per table
    localparam int SPAN   = 2 * PTS;      // half-step positions per sweep
    localparam int XW     = 10;           // half-step position width
    localparam int IW     = 9;            // table index width
    localparam int AW     = 10;           // memory address width
    localparam int DW     = 8;            // sample width
    localparam int B_BASE = 512;          // first address of table B
    localparam int MID    = 128;          // midscale for the difference view

    typedef enum logic [1:0] {
        VIEW_A    = 2'd0,
        VIEW_B    = 2'd1,
        VIEW_BOTH = 2'd2,
        VIEW_DIFF = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        TR_MAIN   = 2'd0,
        TR_SECOND = 2'd1,
        TR_ARITH  = 2'd2
    } trace_e;

    typedef struct packed {
        logic          tbl;   // 0 table A, 1 table B
        logic [IW-1:0] idx;
    } slot_t;

    typedef struct packed {
        logic          emit;  // 0: first read of a difference pair
        trace_e        trace;
        logic [XW-1:0] x;
    } tag_t;

    function automatic logic [XW-1:0] frame_last(view_e v);
        if (v == VIEW_A || v == VIEW_B) return XW'(PTS - 1);
        return XW'(SPAN - 1);
    endfunction

    function automatic slot_t map_step(view_e v, logic sep, logic [XW-1:0] step);
        slot_t         s;
        logic [XW-1:0] rel;
        rel = step - XW'(PTS);
        case (v)
            VIEW_A: begin s.tbl = 1'b0; s.idx = step[IW-1:0]; end
            VIEW_B: begin s.tbl = 1'b1; s.idx = step[IW-1:0]; end
            VIEW_BOTH: begin
                if (!sep) begin
                    s.tbl = step[0]; s.idx = step[XW-1:1];
                end else if (step >= XW'(PTS)) begin
                    s.tbl = 1'b1; s.idx = rel[IW-1:0];
                end else begin
                    s.tbl = 1'b0; s.idx = step[IW-1:0];
                end
            end
            default: begin s.tbl = step[0]; s.idx = step[XW-1:1]; end
        endcase
        return s;
    endfunction

    function automatic logic [XW-1:0] point_x(view_e v, slot_t s);
        if (v == VIEW_DIFF) return {s.idx, 1'b0};
        return {s.idx, s.tbl};
    endfunction

    function automatic trace_e point_trace(view_e v, logic sep, slot_t s);
        if (v == VIEW_DIFF) return TR_ARITH;
        if (v == VIEW_BOTH && sep && s.tbl) return TR_SECOND;
        return TR_MAIN;
    endfunction

    function automatic logic [AW-1:0] slot_addr(slot_t s);
        return {1'b0, s.idx} + (s.tbl ? AW'(B_BASE) : AW'(0));
    endfunction

    function automatic logic [DW-1:0] diff_clamp(logic [DW-1:0] a, logic [DW-1:0] b);
        int t;
        t = int'(b) - int'(a) + MID;
        if (t < 0) return '0;
        if (t > (1 << DW) - 1) return '1;
        return DW'(t);
    endfunction

endpackage

// File: rtl/dts_acq.sv
module dts_acq
    import dts_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [DW-1:0] data,
    input  logic          save_a,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [XW-1:0] pos
);

    localparam logic [XW-1:0] LAST = XW'(SPAN - 1);

    slot_t slot;

    always_comb begin
        slot.tbl = pos[0];
        slot.idx = pos[XW-1:1];
        wr_addr  = slot_addr(slot);
        wr_data  = data;
        wr_req   = strobe && !(save_a && !pos[0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (strobe) begin
            pos <= (pos == LAST) ? '0 : pos + 1'b1;
        end
    end

    AST_ACQ_WRAP: assert property (@(posedge clk) disable iff (rst)
        (strobe && pos == LAST) |=> (pos == '0)); // R2

endmodule

// File: rtl/dts_table_ram.sv
module dts_table_ram #(
    parameter int A_W = 10,
    parameter int D_W = 8
) (
    input  logic           clk,
    input  logic           we,
    input  logic [A_W-1:0] addr,
    input  logic [D_W-1:0] wdata,
    output logic [D_W-1:0] rdata
);

    localparam int DEPTH = 1 << A_W;

    logic [D_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/dts_disp_seq.sv
module dts_disp_seq
    import dts_pkg::*;
#(
    parameter int PAUSE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [1:0]    view_in,
    input  logic          sep_in,
    input  logic [XW-1:0] acq_pos,
    input  logic          wr_busy,
    output logic          issue,
    output logic [AW-1:0] rd_addr,
    output tag_t          rd_tag,
    output logic          marker
);

    localparam int PCW = $clog2(PAUSE_CYC + 1);

    logic [XW-1:0]  step;
    view_e          cur_view;
    logic           cur_sep;
    logic [PCW-1:0] pause_cnt;
    logic           hit_done;

    view_e          eff_view;
    logic           eff_sep;
    slot_t          slot;
    logic [XW-1:0]  px;
    logic           hit;

    always_comb begin
        eff_view     = (step == '0) ? view_e'(view_in) : cur_view;
        eff_sep      = (step == '0) ? sep_in : cur_sep;
        slot         = map_step(eff_view, eff_sep, step);
        px           = point_x(eff_view, slot);
        marker       = (pause_cnt != '0);
        hit          = run && !marker && !hit_done && (px == acq_pos);
        issue        = run && !marker && !hit && !wr_busy;
        rd_addr      = slot_addr(slot);
        rd_tag.x     = px;
        rd_tag.trace = point_trace(eff_view, eff_sep, slot);
        rd_tag.emit  = !(eff_view == VIEW_DIFF && !slot.tbl);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            step      <= '0;
            cur_view  <= VIEW_A;
            cur_sep   <= 1'b0;
            pause_cnt <= '0;
            hit_done  <= 1'b0;
        end else if (marker) begin
            pause_cnt <= pause_cnt - 1'b1;
        end else if (hit) begin
            pause_cnt <= PCW'(PAUSE_CYC);
            hit_done  <= 1'b1;
        end else if (issue) begin
            if (step == '0) begin
                cur_view <= eff_view;
                cur_sep  <= eff_sep;
            end
            step     <= (step == frame_last(eff_view)) ? '0 : step + 1'b1;
            hit_done <= 1'b0;
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        step < XW'(SPAN)); // R11

    AST_HELD_VIEW: assert property (@(posedge clk) disable iff (rst)
        (run && step != '0 && $past(run) && $past(step) != '0) |-> $stable(cur_view)); // R11

endmodule

// File: rtl/dts_out_stage.sv
module dts_out_stage
    import dts_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_valid,
    input  tag_t          rd_tag,
    input  logic [DW-1:0] rdata,
    output logic          disp_valid,
    output logic [XW-1:0] disp_x,
    output logic [DW-1:0] disp_y,
    output logic [1:0]    disp_trace
);

    logic [DW-1:0] a_hold;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            disp_valid <= 1'b0;
            disp_x     <= '0;
            disp_y     <= '0;
            disp_trace <= TR_MAIN;
            a_hold     <= '0;
        end else begin
            disp_valid <= rd_valid && rd_tag.emit;
            if (rd_valid && !rd_tag.emit) a_hold <= rdata;
            if (rd_valid && rd_tag.emit) begin
                disp_x     <= rd_tag.x;
                disp_trace <= rd_tag.trace;
                disp_y     <= (rd_tag.trace == TR_ARITH) ? diff_clamp(a_hold, rdata) : rdata;
            end
        end
        if (rst_q && !rst) begin
            AST_RESET_IDLE: assert (!disp_valid); // R1
        end
    end

    AST_ARITH_EVEN_X: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_trace == TR_ARITH) |-> !disp_x[0]); // R8

    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_x < XW'(SPAN))); // R6

endmodule

// File: rtl/dts_sequencer.sv
module dts_sequencer
    import dts_pkg::*;
#(
    parameter int PAUSE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acq_strobe,
    input  logic [DW-1:0] acq_data,
    input  logic          save_a,
    input  logic [1:0]    view_sel,
    input  logic          disp_run,
    output logic          disp_valid,
    output logic [XW-1:0] disp_x,
    output logic [DW-1:0] disp_y,
    output logic [1:0]    disp_trace,
    output logic          marker_pause
);

    logic          wr_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [XW-1:0] acq_pos;

    logic          rd_issue;
    logic [AW-1:0] rd_addr;
    tag_t          rd_tag;

    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          rd_valid_q;
    tag_t          rd_tag_q;

    dts_acq u_acq (
        .clk     (clk),
        .rst     (rst),
        .strobe  (acq_strobe),
        .data    (acq_data),
        .save_a  (save_a),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pos     (acq_pos)
    );

    dts_disp_seq #(.PAUSE_CYC(PAUSE_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (disp_run),
        .view_in (view_sel),
        .sep_in  (save_a),
        .acq_pos (acq_pos),
        .wr_busy (wr_req),
        .issue   (rd_issue),
        .rd_addr (rd_addr),
        .rd_tag  (rd_tag),
        .marker  (marker_pause)
    );

    // 10-bit address multiplexer: the acquisition write owns the port
    assign mem_addr = wr_req ? wr_addr : rd_addr;

    dts_table_ram #(.A_W(AW), .D_W(DW)) u_ram (
        .clk   (clk),
        .we    (wr_req),
        .addr  (mem_addr),
        .wdata (wr_data),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_tag_q   <= '0;
        end else begin
            rd_valid_q <= rd_issue;
            rd_tag_q   <= rd_tag;
        end
    end

    dts_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .rd_valid   (rd_valid_q),
        .rd_tag     (rd_tag_q),
        .rdata      (mem_rdata),
        .disp_valid (disp_valid),
        .disp_x     (disp_x),
        .disp_y     (disp_y),
        .disp_trace (disp_trace)
    );

    AST_SAVE_A_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr_req && save_a) |-> mem_addr[AW-1]); // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !rd_valid_q); // R9

    AST_MARKER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        marker_pause |=> !rd_valid_q); // R10

endmodule

// File: tb/sim_dts_sequencer.sv
module sim_dts_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE_CYC  = 4;

    typedef struct {
        int    x;
        int    y;
        int    tr;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq_strobe = 1'b0;
    logic [7:0] acq_data = '0;
    logic       save_a = 1'b0;
    logic [1:0] view_sel = '0;
    logic       disp_run = 1'b0;
    logic       disp_valid;
    logic [9:0] disp_x;
    logic [7:0] disp_y;
    logic [1:0] disp_trace;
    logic       marker_pause;

    int   ta [500];
    int   tb [500];
    int   apos = 0;
    exp_t q [$];

    int compared = 0;
    int mismatched = 0;
    bit mon_en = 1'b0;
    bit seen = 1'b0;
    int mk_cnt = 0;
    int pre_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dts_sequencer #(.PAUSE_CYC(PAUSE_CYC)) u0 (
        .clk          (clk),
        .rst          (rst),
        .acq_strobe   (acq_strobe),
        .acq_data     (acq_data),
        .save_a       (save_a),
        .view_sel     (view_sel),
        .disp_run     (disp_run),
        .disp_valid   (disp_valid),
        .disp_x       (disp_x),
        .disp_y       (disp_y),
        .disp_trace   (disp_trace),
        .marker_pause (marker_pause)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input int x, input int y, input int tr, input string tag);
        exp_t e;
        e.x = x; e.y = y; e.tr = tr; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops expected points as the design emits them
    always @(negedge clk) begin : monitor
        exp_t e;
        if (mon_en) begin
            if (marker_pause && q.size() > 0) mk_cnt++;
            if (marker_pause && !seen) pre_cnt++;
            if (disp_valid) begin
                seen = 1'b1;
                if (q.size() > 0) begin
                    e = q.pop_front();
                    compared++;
                    if (int'(disp_x) != e.x || int'(disp_y) != e.y || int'(disp_trace) != e.tr) begin
                        mismatched++;
                        $display("FAIL %s actual x=%0d y=%0d tr=%0d expected x=%0d y=%0d tr=%0d",
                                 e.tag, disp_x, disp_y, disp_trace, e.x, e.y, e.tr);
                    end
                end
            end
        end
    end

    task automatic sweep(input int n, input bit sv, input int mul, input int add);
        save_a = sv;
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            acq_strobe = 1'b1;
            acq_data   = 8'((apos * mul + add) & 255);
            if (apos % 2 == 1) tb[apos / 2] = (apos * mul + add) & 255;
            else if (!sv)      ta[apos / 2] = (apos * mul + add) & 255;
            apos = (apos + 1) % 1000;
        end
        @(negedge clk);
        acq_strobe = 1'b0;
    endtask

    task automatic run_frame(input int view, input bit sv, input bit switch_mid);
        int t;
        view_sel = 2'(view);
        save_a   = sv;
        case (view)
            0: for (int i = 0; i < 500; i++) push(2 * i, ta[i], 0, "R4");
            1: for (int i = 0; i < 500; i++) push(2 * i + 1, tb[i], 0, "R5");
            2: if (!sv) begin
                   for (int k = 0; k < 1000; k++)
                       push(k, (k % 2 == 0) ? ta[k / 2] : tb[k / 2], 0, "R6");
               end else begin
                   for (int i = 0; i < 500; i++) push(2 * i, ta[i], 0, "R7");
                   for (int i = 0; i < 500; i++) push(2 * i + 1, tb[i], 1, "R7");
               end
            default: for (int i = 0; i < 500; i++) begin
                t = 128 + tb[i] - ta[i];
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                push(2 * i, t, 2, "R8");
            end
        endcase
        mk_cnt = 0; pre_cnt = 0; seen = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        disp_run = 1'b1;
        if (switch_mid) begin
            repeat (50) @(negedge clk);
            view_sel = 2'(view ^ 1); // R11: must not affect this frame
        end
        while (q.size() != 0) @(negedge clk);
        disp_run = 1'b0;
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R11 watchdog expired, queue=%0d expected=0", q.size());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : driver
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(disp_valid == 1'b0, "R1 valid", int'(disp_valid), 0);
        check(marker_pause == 1'b0, "R1 marker", int'(marker_pause), 0);

        // full sweep, position starts at 0 (R1) and wraps back to 0 (R2)
        sweep(1000, 1'b0, 37, 5);
        run_frame(0, 1'b0, 1'b0);                          // R4, R2
        check(pre_cnt == PAUSE_CYC, "R10 pause at x=0", pre_cnt, PAUSE_CYC);
        run_frame(1, 1'b0, 1'b0);                          // R5
        run_frame(2, 1'b0, 1'b0);                          // R6

        // second sweep with A frozen (R3)
        sweep(1000, 1'b1, 91, 200);
        run_frame(2, 1'b1, 1'b0);                          // R7, R3
        run_frame(3, 1'b0, 1'b0);                          // R8

        // partial sweep: position ends at 7
        sweep(7, 1'b0, 13, 77);
        run_frame(2, 1'b0, 1'b0);                          // R6
        check(mk_cnt == PAUSE_CYC, "R10 merged pause at x=7", mk_cnt, PAUSE_CYC);
        run_frame(0, 1'b0, 1'b1);                          // R11 mid-frame change
        check(mk_cnt == 0, "R10 no match in A view", mk_cnt, 0);
        run_frame(1, 1'b0, 1'b0);                          // R5 after partial sweep

        // R9: back-to-back writes block display reads
        view_sel = 2'd0;
        save_a   = 1'b0;
        disp_run = 1'b1;
        repeat (10) @(negedge clk);
        cnt = 0;
        for (int j = 0; j < 200; j++) begin
            @(negedge clk);
            if (j >= 3 && disp_valid) cnt++;
            acq_strobe = 1'b1;
            acq_data   = 8'(j);
        end
        @(negedge clk);
        acq_strobe = 1'b0;
        disp_run   = 1'b0;
        check(cnt == 0, "R9 reads during writes", cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule